// File: doc/BRIEF.md
# PHY Control and Status Register File

This block holds the two basic management registers of an Ethernet PHY: a control word that sets the operating mode and issues commands, and a read-only status word that reports link health and fixed abilities. A management agent, normally an MDIO frame engine outside this block, reaches them through a simple port. The port carries a 5-bit register address, a write strobe with 16-bit data, and a read strobe. Read data is combinational and valid in the cycle the read strobe is high.

The control word drives level mode signals straight into the PHY core: loopback, 100 Mb/s select, auto-negotiation enable, power-down, isolate, full duplex and collision test. Two command bits clear themselves. The soft-reset command puts every register back to its default, gives the PHY core a one-cycle reset pulse, and stays visible until the core reports that the reset has finished. The restart command gives the auto-negotiation logic a one-cycle pulse and then drops. Auto-negotiation can also load the duplex bit.

Status reports link and auto-negotiation-complete live from the core. Remote fault and jabber are latched: each stays set until the status register is read. The capability bits are fixed.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset the control register (address 0) reads 0x3100. The mode outputs are then 100 Mb/s select = 1, auto-negotiation enable = 1, full duplex = 1, and all others 0.
- R2: The control bits loopback (14), speed (13, 1 = 100 Mb/s), auto-negotiation enable (12), power-down (11), isolate (10), duplex (8, 1 = full) and collision test (7) store the written value. They read back from the next cycle, and the matching mode outputs follow them.
- R3: Control bits 6:0 always read 0, whatever was written to them.
- R4: Writing 1 to control bit 9 raises restart_pulse_o for exactly one cycle, the cycle after the write. Bit 9 reads 0 from the cycle after that.
- R5: Writing 1 to control bit 15 discards the other written bits and loads the control register with 0xB100. It raises phy_rst_pulse_o for the single following cycle and clears both latched status bits. Bit 15 stays 1 until rst_done_i is seen high, after which the register reads 0x3100.
- R6: The status register (address 1) reads 1 in bits 14:11, 6, 3 and 0 and reads 0 in bits 15 and 10:7. With all status inputs low it reads 0x7849.
- R7: Status bit 2 (link) and bit 5 (auto-negotiation complete) show link_up_i and an_done_i in the same cycle, without latching.
- R8: Status bit 4 (remote fault) and bit 1 (jabber) are set one cycle after their input is seen high. They stay 1 after the input falls, until a read of address 1. That read returns 1, and later reads return 0.
- R9: If a latched condition is still high in the cycle of the clearing read, the bit is 1 again on the next cycle.
- R10: When dup_upd_i is high, control bit 8 takes dup_val_i at the next edge. A management write to the control register in the same cycle takes precedence.
- R11: Reads from any address other than 0 and 1 return 0. Writes to those addresses, and to the status register, change nothing that can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe; a read of address 1 clears latched bits |
| rd_data | output | 16 | Read data, valid while rd_en is high, else 0 |
| link_up_i | input | 1 | Live link state from the PHY core |
| an_done_i | input | 1 | Auto-negotiation complete |
| rflt_i | input | 1 | Remote fault condition |
| jab_i | input | 1 | Jabber condition |
| rst_done_i | input | 1 | PHY core has finished a soft reset |
| dup_upd_i | input | 1 | Auto-negotiation duplex update strobe |
| dup_val_i | input | 1 | Duplex value to load (1 = full) |
| lpbk_o | output | 1 | Loopback mode |
| spd100_o | output | 1 | 100 Mb/s select |
| an_en_o | output | 1 | Auto-negotiation enable |
| pwrdn_o | output | 1 | Power-down |
| iso_o | output | 1 | Isolate |
| fdx_o | output | 1 | Full duplex |
| colt_o | output | 1 | Collision test |
| phy_rst_pulse_o | output | 1 | One-cycle soft-reset pulse to the PHY core |
| restart_pulse_o | output | 1 | One-cycle auto-negotiation restart pulse |

## Verification
The properties assume that every input is free of X and synchronous to clk, and that reg_addr is held steady while a strobe is high. They also assume that rst_done_i is only raised after a soft-reset pulse. The pulse and latch properties further take it that a command or condition is not issued again in the cycle being checked. The bench drives every input just after the falling edge, keeps them fixed for a whole cycle, and asserts completion and condition inputs only when the scenario being tested calls for them.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int REG_AW = 5;
    localparam int REG_DW = 16;

    localparam logic [REG_AW-1:0] CTRL_ADDR = 5'd0;
    localparam logic [REG_AW-1:0] STAT_ADDR = 5'd1;

    // control bit positions
    localparam int B_RST   = 15;
    localparam int B_LPBK  = 14;
    localparam int B_SPD   = 13;
    localparam int B_ANEN  = 12;
    localparam int B_PDN   = 11;
    localparam int B_ISO   = 10;
    localparam int B_RSTRT = 9;
    localparam int B_DUP   = 8;
    localparam int B_COLT  = 7;

    localparam logic [REG_DW-1:0] CTRL_DEFAULT = 16'h3100;
    // bits that hold the written value as-is
    localparam logic [REG_DW-1:0] CTRL_RW_MASK = 16'h7D80;

    // status bit positions
    localparam int S_ANDONE = 5;
    localparam int S_RFLT   = 4;
    localparam int S_LINK   = 2;
    localparam int S_JAB    = 1;

    localparam logic [REG_DW-1:0] STAT_FIXED = 16'h7849;

    typedef struct packed {
        logic [REG_DW-1:0] word;
        logic              rst_fire;
    } ctrl_state_t;

    typedef struct packed {
        logic rflt;
        logic jab;
    } sticky_t;

endpackage

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
    import phy_mgmt_pkg::*;
#(
    parameter int DW = REG_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic [DW-1:0] wr_data,
    input  logic          rst_done,
    input  logic          dup_upd,
    input  logic          dup_val,
    output logic [DW-1:0] ctrl_word,
    output logic          rst_fire,
    output logic          soft_rst
);

    ctrl_state_t st_d, st_q;
    logic        rst_hold;

    assign soft_rst = wr_ctrl & wr_data[B_RST];

    always_comb begin
        st_d          = st_q;
        st_d.rst_fire = 1'b0;
        // restart command lives for exactly one cycle
        st_d.word[B_RSTRT] = 1'b0;
        if (rst_done) begin
            st_d.word[B_RST] = 1'b0;
        end
        if (dup_upd) begin
            st_d.word[B_DUP] = dup_val;
        end
        rst_hold = st_d.word[B_RST];
        if (wr_ctrl) begin
            if (wr_data[B_RST]) begin
                st_d.word          = CTRL_DEFAULT;
                st_d.word[B_RST]   = 1'b1;
                st_d.rst_fire      = 1'b1;
            end else begin
                st_d.word          = wr_data & CTRL_RW_MASK;
                st_d.word[B_RSTRT] = wr_data[B_RSTRT];
                st_d.word[B_RST]   = rst_hold;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word     <= CTRL_DEFAULT;
            st_q.rst_fire <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_word = st_q.word;
    assign rst_fire  = st_q.rst_fire;

endmodule

// File: rtl/phy_stat_reg.sv
module phy_stat_reg
    import phy_mgmt_pkg::*;
#(
    parameter int DW = REG_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_up,
    input  logic          an_done,
    input  logic          rflt_in,
    input  logic          jab_in,
    input  logic          rd_clr,
    input  logic          soft_rst,
    output logic [DW-1:0] stat_word,
    output logic          rflt_q,
    output logic          jab_q
);

    sticky_t stk_d, stk_q;
    logic    drop;

    always_comb begin
        drop       = rd_clr | soft_rst;
        stk_d.rflt = rflt_in | (stk_q.rflt & ~drop);
        stk_d.jab  = jab_in  | (stk_q.jab  & ~drop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    always_comb begin
        stat_word           = STAT_FIXED;
        stat_word[S_LINK]   = link_up;
        stat_word[S_ANDONE] = an_done;
        stat_word[S_RFLT]   = stk_q.rflt;
        stat_word[S_JAB]    = stk_q.jab;
    end

    assign rflt_q = stk_q.rflt;
    assign jab_q  = stk_q.jab;

endmodule

// File: rtl/phy_rd_mux.sv
module phy_rd_mux
    import phy_mgmt_pkg::*;
#(
    parameter int AW = REG_AW,
    parameter int DW = REG_DW
) (
    input  logic [AW-1:0] addr,
    input  logic          rd_en,
    input  logic [DW-1:0] ctrl_word,
    input  logic [DW-1:0] stat_word,
    output logic [DW-1:0] rd_data
);

    localparam int NREG = 2;
    logic [DW-1:0] slot [NREG];
    logic [NREG-1:0] hit;

    assign slot[0] = ctrl_word;
    assign slot[1] = stat_word;

    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign hit[g] = (addr == AW'(g));
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_en && hit[i]) begin
                rd_data = slot[i];
            end
        end
    end

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int AW = REG_AW,
    parameter int DW = REG_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          link_up_i,
    input  logic          an_done_i,
    input  logic          rflt_i,
    input  logic          jab_i,
    input  logic          rst_done_i,
    input  logic          dup_upd_i,
    input  logic          dup_val_i,
    output logic          lpbk_o,
    output logic          spd100_o,
    output logic          an_en_o,
    output logic          pwrdn_o,
    output logic          iso_o,
    output logic          fdx_o,
    output logic          colt_o,
    output logic          phy_rst_pulse_o,
    output logic          restart_pulse_o
);

    logic          wr_ctrl;
    logic          rd_clr;
    logic          soft_rst;
    logic          rflt_q;
    logic          jab_q;
    logic [DW-1:0] ctrl_word;
    logic [DW-1:0] stat_word;

    assign wr_ctrl = wr_en & (reg_addr == AW'(CTRL_ADDR));
    assign rd_clr  = rd_en & (reg_addr == AW'(STAT_ADDR));

    phy_ctrl_reg #(.DW(DW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wr_data  (wr_data),
        .rst_done (rst_done_i),
        .dup_upd  (dup_upd_i),
        .dup_val  (dup_val_i),
        .ctrl_word(ctrl_word),
        .rst_fire (phy_rst_pulse_o),
        .soft_rst (soft_rst)
    );

    phy_stat_reg #(.DW(DW)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_up  (link_up_i),
        .an_done  (an_done_i),
        .rflt_in  (rflt_i),
        .jab_in   (jab_i),
        .rd_clr   (rd_clr),
        .soft_rst (soft_rst),
        .stat_word(stat_word),
        .rflt_q   (rflt_q),
        .jab_q    (jab_q)
    );

    phy_rd_mux #(.AW(AW), .DW(DW)) u_mux (
        .addr     (reg_addr),
        .rd_en    (rd_en),
        .ctrl_word(ctrl_word),
        .stat_word(stat_word),
        .rd_data  (rd_data)
    );

    assign lpbk_o          = ctrl_word[B_LPBK];
    assign spd100_o        = ctrl_word[B_SPD];
    assign an_en_o         = ctrl_word[B_ANEN];
    assign pwrdn_o         = ctrl_word[B_PDN];
    assign iso_o           = ctrl_word[B_ISO];
    assign fdx_o           = ctrl_word[B_DUP];
    assign colt_o          = ctrl_word[B_COLT];
    assign restart_pulse_o = ctrl_word[B_RSTRT];

endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk #(
    parameter int AW = 5,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] reg_addr,
    input logic          wr_en,
    input logic [DW-1:0] wr_data,
    input logic          rd_en,
    input logic [DW-1:0] rd_data,
    input logic          rflt_i,
    input logic          jab_i,
    input logic          rflt_q,
    input logic          jab_q,
    input logic [DW-1:0] ctrl_word,
    input logic          phy_rst_pulse_o,
    input logic          restart_pulse_o
);

    logic wr_c, rd_s, rd_c, cmd_rst, cmd_rs;
    assign wr_c    = wr_en && (reg_addr == AW'(0));
    assign rd_c    = rd_en && (reg_addr == AW'(0));
    assign rd_s    = rd_en && (reg_addr == AW'(1));
    assign cmd_rst = wr_c && wr_data[15];
    assign cmd_rs  = wr_c && wr_data[9] && !wr_data[15];

    assert_restart_fires_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rs |=> restart_pulse_o);
    assert_restart_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_pulse_o && !cmd_rs) |=> !restart_pulse_o);
    assert_rst_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst |=> (phy_rst_pulse_o && ctrl_word[15]));
    assert_rst_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_rst_pulse_o && !cmd_rst) |=> !phy_rst_pulse_o);
    assert_resv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_c |-> (rd_data[6:0] == 7'd0));
    assert_fixed_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_s |-> ((rd_data & 16'hFFC9) == 16'h7849));
    assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_addr > AW'(1)) |-> (rd_data == '0));
    assert_rflt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rflt_q && !rd_s && !cmd_rst) |=> rflt_q);
    assert_jab_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (jab_q && !rd_s && !cmd_rst) |=> jab_q);
    assert_rflt_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rflt_i |=> rflt_q);
    assert_jab_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        jab_i |=> jab_q);

endmodule

bind phy_mgmt_regs phy_mgmt_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_addr       (reg_addr),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .rd_en          (rd_en),
    .rd_data        (rd_data),
    .rflt_i         (rflt_i),
    .jab_i          (jab_i),
    .rflt_q         (rflt_q),
    .jab_q          (jab_q),
    .ctrl_word      (ctrl_word),
    .phy_rst_pulse_o(phy_rst_pulse_o),
    .restart_pulse_o(restart_pulse_o)
);

// File: tb/sim_phy_mgmt_regs.sv
module sim_phy_mgmt_regs;

    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        link_up_i = 1'b0, an_done_i = 1'b0, rflt_i = 1'b0, jab_i = 1'b0;
    logic        rst_done_i = 1'b0, dup_upd_i = 1'b0, dup_val_i = 1'b0;
    logic        lpbk_o, spd100_o, an_en_o, pwrdn_o, iso_o, fdx_o, colt_o;
    logic        phy_rst_pulse_o, restart_pulse_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    phy_mgmt_regs u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .link_up_i(link_up_i), .an_done_i(an_done_i), .rflt_i(rflt_i),
        .jab_i(jab_i), .rst_done_i(rst_done_i), .dup_upd_i(dup_upd_i),
        .dup_val_i(dup_val_i), .lpbk_o(lpbk_o), .spd100_o(spd100_o),
        .an_en_o(an_en_o), .pwrdn_o(pwrdn_o), .iso_o(iso_o), .fdx_o(fdx_o),
        .colt_o(colt_o), .phy_rst_pulse_o(phy_rst_pulse_o),
        .restart_pulse_o(restart_pulse_o)
    );

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [4:0]  addr;
        logic [15:0] wd;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b1, 5'd0,  16'h0000, 16'h3100, 4'd1},  // R1 control default
        '{1'b0, 1'b1, 5'd1,  16'h0000, 16'h7849, 4'd6},  // R6 status default
        '{1'b1, 1'b0, 5'd0,  16'h4CFF, 16'h0000, 4'd2},  // R2 write mode bits + reserved
        '{1'b0, 1'b1, 5'd0,  16'h0000, 16'h4C80, 4'd3},  // R3 reserved reads 0
        '{1'b1, 1'b0, 5'd0,  16'h2100, 16'h0000, 4'd2},
        '{1'b0, 1'b1, 5'd0,  16'h0000, 16'h2100, 4'd2},  // R2 speed/duplex
        '{1'b1, 1'b0, 5'd0,  16'h3100, 16'h0000, 4'd2},
        '{1'b1, 1'b0, 5'd1,  16'hFFFF, 16'h0000, 4'd11},
        '{1'b0, 1'b1, 5'd1,  16'h0000, 16'h7849, 4'd11}, // R11 status write ignored
        '{1'b1, 1'b0, 5'd5,  16'hFFFF, 16'h0000, 4'd11},
        '{1'b0, 1'b1, 5'd5,  16'h0000, 16'h0000, 4'd11}, // R11 unmapped reads 0
        '{1'b0, 1'b1, 5'd31, 16'h0000, 16'h0000, 4'd11},
        '{1'b0, 1'b1, 5'd0,  16'h0000, 16'h3100, 4'd11}, // R11 control untouched
        '{1'b0, 1'b1, 5'd1,  16'h0000, 16'h7849, 4'd6}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 1'b0; rd_en = 1'b0; wr_data = '0; reg_addr = '0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        step();
        idle();
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [15:0] exp);
        reg_addr = a; rd_en = 1'b1;
        #1;
        check(tag, rd_data, exp);
        step();
        idle();
    endtask

    function automatic logic [15:0] modes();
        return {9'd0, lpbk_o, spd100_o, an_en_o, pwrdn_o, iso_o, fdx_o, colt_o};
    endfunction

    initial begin
        #(CLK_PER * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 modes at reset", modes(), 16'h0032);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            wr_en = TBL[i].wr; rd_en = TBL[i].rd;
            reg_addr = TBL[i].addr; wr_data = TBL[i].wd;
            #1;
            if (TBL[i].rd) begin
                n_chk++;
                if (rd_data !== TBL[i].exp) begin
                    n_fail++;
                    $display("FAIL R%0d vector %0d: actual 0x%04h expected 0x%04h",
                             TBL[i].req, i, rd_data, TBL[i].exp);
                end
            end
            step();
            idle();
        end

        // R2 mode outputs follow the stored bits
        wr(5'd0, 16'h4C80);
        check("R2 mode outputs", modes(), 16'h004D);
        wr(5'd0, 16'h3100);

        // R4 restart command
        wr(5'd0, 16'h1200);
        check("R4 restart pulse high", {15'd0, restart_pulse_o}, 16'd1);
        step();
        check("R4 restart pulse low", {15'd0, restart_pulse_o}, 16'd0);
        rd_chk("R4 bit9 self cleared", 5'd0, 16'h1000);

        // R5 soft reset, with a latched remote fault pending
        rflt_i = 1'b1; step(); rflt_i = 1'b0;
        wr(5'd0, 16'hC0FF);
        check("R5 reset pulse high", {15'd0, phy_rst_pulse_o}, 16'd1);
        rd_chk("R5 control during reset", 5'd0, 16'hB100);
        check("R5 reset pulse low", {15'd0, phy_rst_pulse_o}, 16'd0);
        rd_chk("R5 sticky cleared by reset", 5'd1, 16'h7849);
        rd_chk("R5 bit15 held", 5'd0, 16'hB100);
        rst_done_i = 1'b1; step(); rst_done_i = 1'b0;
        rd_chk("R5 bit15 cleared on done", 5'd0, 16'h3100);

        // R7 live status bits
        link_up_i = 1'b1; an_done_i = 1'b1;
        rd_chk("R7 link and an_done live", 5'd1, 16'h786D);
        link_up_i = 1'b0; an_done_i = 1'b0;
        rd_chk("R7 no latching", 5'd1, 16'h7849);

        // R8 sticky remote fault and jabber
        rflt_i = 1'b1; step(); rflt_i = 1'b0;
        step();
        rd_chk("R8 remote fault latched", 5'd1, 16'h7859);
        rd_chk("R8 remote fault cleared", 5'd1, 16'h7849);
        jab_i = 1'b1; step(); jab_i = 1'b0;
        rd_chk("R8 control read keeps latch", 5'd0, 16'h3100);
        rd_chk("R8 jabber latched", 5'd1, 16'h784B);
        rd_chk("R8 jabber cleared", 5'd1, 16'h7849);

        // R9 condition persisting through the clearing read
        jab_i = 1'b1; step();
        rd_chk("R9 read while active", 5'd1, 16'h784B);
        jab_i = 1'b0;
        rd_chk("R9 re-set after read", 5'd1, 16'h784B);
        rd_chk("R9 finally cleared", 5'd1, 16'h7849);

        // R10 duplex update from auto-negotiation
        dup_upd_i = 1'b1; dup_val_i = 1'b0; step();
        dup_upd_i = 1'b0;
        rd_chk("R10 duplex loaded 0", 5'd0, 16'h3000);
        dup_upd_i = 1'b1; dup_val_i = 1'b1;
        wr(5'd0, 16'h3000);
        dup_upd_i = 1'b0;
        rd_chk("R10 write wins", 5'd0, 16'h3000);
        dup_upd_i = 1'b1; dup_val_i = 1'b1; step();
        dup_upd_i = 1'b0;
        rd_chk("R10 duplex loaded 1", 5'd0, 16'h3100);
        check("R10 fdx output", {15'd0, fdx_o}, 16'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule